// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table stored in physical memory. A translation request carries the virtual address, a write flag and a user-mode flag. The walker performs at most two word reads on its memory port. The first read fetches a directory entry located by a base register. The second read fetches a leaf entry. The walker then returns either the physical address or a fault code that names the reason for refusal.

The virtual address splits into three fields. The top 10 bits index the directory. The next 10 bits index the leaf table. The low 12 bits are the byte offset within a 4 KB page. Every entry is a 32-bit word, so each table fills exactly one page. Software loads the base register through a one-cycle write strobe. The walker handles one translation at a time. It holds each result on its outputs until the requester acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_rd_en` is 0 and `rsp_valid` is 0. The base register also resets to 0.
- R2: A request is accepted on a clock edge where `req_ready` and `req_valid` are both 1. From the next cycle, the walker reads the directory entry at base + vaddr[31:22]×4.
- R3: A directory entry is valid when its bit 0 is 1. If bit 0 is 0, the walker responds with fault code 1 and makes no second read.
- R4: A valid directory entry triggers a leaf read at {entry[31:12], vaddr[21:12], 2'b00}.
- R5: A leaf entry with bit 0 equal to 0 produces fault code 2.
- R6: In a valid leaf entry, bit 2 means "user access allowed". A user-mode request to a leaf whose bit 2 is 0 produces fault code 4. This check takes priority over R7.
- R7: In a valid leaf entry, bit 1 means "writable". A write to a leaf whose bit 1 is 0 produces fault code 3. A read of the same leaf succeeds.
- R8: A walk that passes every check responds with fault code 0 and `rsp_paddr` = {leaf[31:12], vaddr[11:0]}.
- R9: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady until an edge where `rsp_ack` is 1. In the following cycle `req_ready` is 1.
- R10: While a walk is in progress, `req_ready` is 0. Any `req_valid` in that period is ignored and does not change the walk.
- R11: A base write takes effect for requests accepted after that write's edge. A base write made during a walk does not change the walk's addresses.
- R12: `mem_rd_en` and `mem_addr` stay steady from the cycle a read is issued until an edge with `mem_rd_valid` at 1. `mem_rd_data` is taken on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New base register value |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| req_ready | output | 1 | Walker is idle and can accept a request |
| mem_rd_en | output | 1 | Memory read request, held until served |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_rd_valid | input | 1 | Memory returns data this cycle |
| mem_rd_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Result is available |
| rsp_paddr | output | 32 | Physical address (meaningful when the fault code is 0) |
| rsp_fault | output | 3 | 0 none, 1 directory invalid, 2 leaf invalid, 3 write to read-only, 4 user to kernel page |
| rsp_ack | input | 1 | Requester has taken the result |

## Verification
The hardest case to reach from the ports is a base register change in the middle of a walk. The new value must be ignored by the current walk and used by the next request. The bench reaches this case by writing a second base value the cycle after a request is accepted. It then translates the same virtual address against a different directory, whose contents give a distinct physical page.

Other stimulus also probes the walker's timing and ordering:
- `req_valid` stays high for a whole walk, to show that requests are ignored while busy.
- Memory latency ranges from zero to several cycles.
- Acknowledgement is delayed.
- One leaf has both the user and the write violation at once, which shows the order in which the rights checks apply.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        base_we,
  input  logic [OFF_W+2*IDX_W-1:0]    base_wdata,
  input  logic                        req_valid,
  input  logic [OFF_W+2*IDX_W-1:0]    req_vaddr,
  input  logic                        req_write,
  input  logic                        req_user,
  output logic                        req_ready,
  output logic                        mem_rd_en,
  output logic [OFF_W+2*IDX_W-1:0]    mem_addr,
  input  logic                        mem_rd_valid,
  input  logic [OFF_W+2*IDX_W-1:0]    mem_rd_data,
  output logic                        rsp_valid,
  output logic [OFF_W+2*IDX_W-1:0]    rsp_paddr,
  output logic [2:0]                  rsp_fault,
  input  logic                        rsp_ack
);
  localparam int AW = OFF_W + 2*IDX_W;
  localparam int FW = AW - OFF_W;
  localparam logic [2:0] F_NONE = 3'd0, F_DIR = 3'd1, F_LEAF = 3'd2,
                         F_RO = 3'd3, F_USER = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_LEAF, S_DONE, S_FAULT} st_t;

  st_t            st;
  logic [AW-1:0]  base_q, va_q, addr_q, paddr_q;
  logic           wr_q, us_q;
  logic [2:0]     fault_q;

  wire pte_v = mem_rd_data[0];
  wire pte_w = mem_rd_data[1];
  wire pte_u = mem_rd_data[2];
  wire [FW-1:0] pte_frame = mem_rd_data[AW-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      fault_q <= F_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          us_q    <= req_user;
          paddr_q <= '0;
          fault_q <= F_NONE;
          addr_q  <= base_q + {{(AW-IDX_W-2){1'b0}}, req_vaddr[AW-1 -: IDX_W], 2'b00};
          st      <= S_DIR;
        end
        S_DIR: if (mem_rd_valid) begin
          if (!pte_v) begin
            fault_q <= F_DIR;
            st      <= S_FAULT;
          end else begin
            addr_q <= {pte_frame, va_q[OFF_W+IDX_W-1:OFF_W], 2'b00};
            st     <= S_LEAF;
          end
        end
        S_LEAF: if (mem_rd_valid) begin
          if (!pte_v) begin
            fault_q <= F_LEAF;
            st      <= S_FAULT;
          end else if (us_q && !pte_u) begin
            fault_q <= F_USER;
            st      <= S_FAULT;
          end else if (wr_q && !pte_w) begin
            fault_q <= F_RO;
            st      <= S_FAULT;
          end else begin
            paddr_q <= {pte_frame, va_q[OFF_W-1:0]};
            st      <= S_DONE;
          end
        end
        S_DONE, S_FAULT: if (rsp_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_rd_en = (st == S_DIR) || (st == S_LEAF);
  assign mem_addr  = addr_q;
  assign rsp_valid = (st == S_DONE) || (st == S_FAULT);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
endmodule

module pt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd_valid,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_paddr,
  input logic [2:0]    rsp_fault,
  input logic          rsp_ack
);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_addr)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |=> req_ready);

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (mem_rd_en || rsp_valid)));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (mem_rd_en && !req_ready));

  // R3
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));
endmodule

bind pt_walker pt_walker_chk #(.AW(OFF_W + 2*IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .rsp_ack(rsp_ack)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        req_ready;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        rsp_ack = 1'b0;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_user(req_user), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_ack(rsp_ack)
  );

  logic [31:0] pmem [logic [31:0]];
  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int lat_cfg = 0;
  int wait_cnt = 0;
  int walks = 0;

  // reference model
  int          ph = 0;
  logic [31:0] m_base = '0, m_va = '0, m_addr = '0, m_paddr = '0;
  logic        m_wr = 1'b0, m_us = 1'b0;
  int          m_fault = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; m_base = '0; m_fault = 0; m_paddr = '0;
    end else begin
      case (ph)
        0: if (req_valid) begin
             m_va = req_vaddr; m_wr = req_write; m_us = req_user;
             m_addr = m_base + 32'(int'(req_vaddr >> 22) * 4);
             ph = 1;
           end
        1: if (mem_rd_valid) begin
             if (mem_rd_data % 2 == 0) begin m_fault = 1; ph = 3; end
             else begin
               m_addr = (mem_rd_data & 32'hFFFF_F000) + 32'(((m_va >> 12) & 32'h3FF) * 4);
               ph = 2;
             end
           end
        2: if (mem_rd_valid) begin
             ph = 3;
             if (!mem_rd_data[0])                   m_fault = 2;
             else if (m_us && !mem_rd_data[2])      m_fault = 4;
             else if (m_wr && !mem_rd_data[1])      m_fault = 3;
             else begin
               m_fault = 0;
               m_paddr = (mem_rd_data & 32'hFFFF_F000) | (m_va & 32'hFFF);
             end
           end
        3: if (rsp_ack) begin ph = 0; walks++; end
        default: ph = 0;
      endcase
      if (base_we) m_base = base_wdata;
    end
  end

  task automatic chk(input string what, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("req_ready", "R1/R10", 32'(req_ready), 32'(ph == 0));
    chk("mem_rd_en", "R1/R2/R12", 32'(mem_rd_en), 32'(ph == 1 || ph == 2));
    if (ph == 1 || ph == 2) chk("mem_addr", "R2/R4/R11", mem_addr, m_addr);
    chk("rsp_valid", "R1/R9", 32'(rsp_valid), 32'(ph == 3));
    if (ph == 3) begin
      chk("rsp_fault", "R3/R5/R6/R7", 32'(rsp_fault), 32'(m_fault));
      if (m_fault == 0) chk("rsp_paddr", "R8", rsp_paddr, m_paddr);
    end
  end

  // memory responder (R12: variable latency)
  always @(negedge clk) begin
    if (mem_rd_en && !mem_rd_valid) begin
      if (wait_cnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = rd_word(mem_addr);
        wait_cnt     = lat_cfg;
      end else wait_cnt--;
    end else begin
      mem_rd_valid = 1'b0;
      mem_rd_data  = 32'hDEAD_BEEF;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  function automatic logic [31:0] va(input int d, input int l, input int off);
    return (32'(d) << 22) | (32'(l) << 12) | 32'(off);
  endfunction

  task automatic translate(input logic [31:0] a, input logic wr, input logic us,
                           input int ackdly, input logic hold, input logic bw,
                           input logic [31:0] nb);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a; req_write = wr; req_user = us;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    req_vaddr = ~a;
    if (bw) begin base_we = 1'b1; base_wdata = nb; end
    @(negedge clk);
    base_we = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (ackdly) @(negedge clk);
    rsp_ack = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    rsp_ack = 1'b0;
  endtask

  localparam logic [31:0] BA = 32'h0001_0000, BB = 32'h0003_0000;

  initial begin
    pmem[BA + 4]          = 32'h0002_0001;
    pmem[BA + 12]         = 32'h0002_1001;
    pmem[BA + 1023*4]     = 32'h0002_2001;
    pmem[32'h20000 + 4]   = 32'h000A_B007;
    pmem[32'h20000 + 8]   = 32'h000A_C003;
    pmem[32'h20000 + 12]  = 32'h000A_D005;
    pmem[32'h20000 + 16]  = 32'h000A_E001;
    pmem[32'h22FFC]       = 32'hFFFF_F007;
    pmem[32'h21000 + 4]   = 32'h0077_7007;
    pmem[BB + 4]          = 32'h0002_1001;

    repeat (3) @(negedge clk);          // R1 reset state compared each cycle
    rst_n = 1'b1;
    @(negedge clk);
    base_we = 1'b1; base_wdata = BA;
    @(negedge clk);
    base_we = 1'b0;

    for (int l = 0; l < 3; l++) begin
      lat_cfg = l; wait_cnt = l;
      translate(va(1, 1, 12'hABC), 1'b0, 1'b1, 0, 1'b0, 1'b0, 0);   // R8
      translate(va(2, 1, 12'h010), 1'b0, 1'b0, l, 1'b0, 1'b0, 0);   // R3
      translate(va(1, 5, 12'h020), 1'b1, 1'b0, 0, 1'b0, 1'b0, 0);   // R5
      translate(va(1, 3, 12'h7F0), 1'b1, 1'b1, 1, 1'b0, 1'b0, 0);   // R7
      translate(va(1, 3, 12'h7F0), 1'b0, 1'b1, 0, 1'b0, 1'b0, 0);   // R7 read ok
      translate(va(1, 2, 12'h004), 1'b0, 1'b1, 0, 1'b0, 1'b0, 0);   // R6
      translate(va(1, 2, 12'h004), 1'b1, 1'b0, 0, 1'b0, 1'b0, 0);   // R6 kernel ok
      translate(va(1, 4, 12'h008), 1'b1, 1'b1, 2, 1'b0, 1'b0, 0);   // R6 over R7
      translate(va(1023, 1023, 12'hFFF), 1'b1, 1'b1, 0, 1'b0, 1'b0, 0); // R2 top index
      translate(va(1, 1, 12'h123), 1'b1, 1'b1, 4, 1'b1, 1'b0, 0);   // R10 held request, R9 late ack
    end

    lat_cfg = 1; wait_cnt = 1;
    translate(va(1, 1, 12'h456), 1'b0, 1'b1, 0, 1'b0, 1'b1, BB);    // R11 mid-walk base write
    translate(va(1, 1, 12'h456), 1'b0, 1'b1, 0, 1'b0, 1'b0, 0);     // R11 new base in use
    translate(va(3, 1, 12'h001), 1'b0, 1'b1, 3, 1'b1, 1'b1, BA);
    translate(va(1, 1, 12'hFEE), 1'b1, 1'b0, 0, 1'b0, 1'b0, 0);

    repeat (4) @(negedge clk);
    vectors++;
    if (walks != 34) begin
      fails++;
      $display("FAIL R9/R10 walk count: actual %0d expected %0d", walks, 34);
    end
    summary();
    $finish;
  end
endmodule